// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers 64 external interrupt lines into a single request line toward an upstream processor. Every source owns a pair of 32-bit configuration words that hold a two-bit enable, a two-bit sense code and an 8-bit priority. Inputs pass through a two-flop synchronizer. Most sources are level-sensitive. A small window of sources (47 to 50) can instead latch a rising or falling edge, and that latch holds until software clears it with a command word.

Among the sources that are pending and enabled, the controller picks the one with the largest priority and registers its number into a status byte. Software reads that byte to find out which source to service. The code 63 in the status byte means that nothing is pending. A global detection enable gates all reporting, and a separate output enable gates the request line. All programming goes through a simple 32-bit register port: writes take effect on the clock edge and reads are combinational.

Top module: `pic64_ctrl`

## Requirements
- R1: After reset, the status register reads 0x3F000000, `irq_out` is low, and every configuration word, the detection enable and the output enable read zero.
- R2: Source n has word A at offset 0x200+8n and word B at offset 0x204+8n. Word A keeps bits 29:28 (enable) and bits 25:24 (sense). Word B keeps bits 7:0 (priority). All other bits read back as zero.
- R3: A source takes part only when both of its enable bits are 1. An enable value of 00, 01 or 10 keeps it out of selection.
- R4: Level sensing: bit 24 of word A gives the active polarity (1 means high is active, 0 means low is active). Every source outside 47..50 is level-sensed, whatever bit 25 holds.
- R5: On sources 47..50, sense code 3 latches a rising edge and code 2 latches a falling edge. The source then stays pending after its input returns to its idle value. Codes 0 and 1 on these sources are level-sensed.
- R6: Writing offset 0x0C0 with bit 8 set clears the edge latch of the source whose number, modulo 16, equals bits 3:0 of the written value. Other latches are untouched. The same write with bit 8 clear has no effect.
- R7: The reported source is the pending, enabled source with the largest priority value. A tie goes to the lower source number. Source 63 is never reported.
- R8: The status register at offset 0x144 holds the selected source number in bits 31:24, or 63 when none is selected. Its other bits read zero.
- R9: Bit 0 at offset 0x004 is the detection enable. While it is 0, the status reads 63 and no edge is latched.
- R10: `irq_out` is high exactly when bit 0 at offset 0x444 is 1 and the status is not 63.
- R11: The 32-bit mask-level word at offset 0x084 reads back as written and does not change which source is reported.
- R12: A level change on `irq_in` shows in the status after the third rising clock edge. An edge event shows after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NSRC | Raw interrupt lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
A wrong edge latch shows up as a status byte that stays stuck on an edge source after a clear, or that misses a source after an edge. Either way it is visible at the next status read, four cycles after the event. A fault in the priority picker or in the stored enable and sense fields reports the wrong source number, or 63, on the first read after the inputs settle. The random phase mixes ties and source-63 traffic so that such faults surface quickly. A latency off by one register is caught by cycle-exact sampling around the third and fourth edges.

// File: rtl/pic64_pkg.sv
package pic64_pkg;
  localparam int unsigned WORD_W = 32;

  // register byte offsets
  localparam int unsigned ADR_DETECT   = 'h004;
  localparam int unsigned ADR_MASKLVL  = 'h084;
  localparam int unsigned ADR_EDGECLR  = 'h0C0;
  localparam int unsigned ADR_STATUS   = 'h144;
  localparam int unsigned ADR_CFG_BASE = 'h200;
  localparam int unsigned ADR_OUTEN    = 'h444;

  // field positions
  localparam int unsigned EN_LSB     = 28;
  localparam int unsigned SENSE_LSB  = 24;
  localparam int unsigned CLR_ARM    = 8;
  localparam int unsigned STAT_LSB   = 24;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_e;

  function automatic bit edge_capable(int unsigned idx, int unsigned lo, int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

  function automatic logic level_match(logic lvl, logic pol);
    return lvl == pol;
  endfunction

  function automatic logic edge_match(logic cur, logic prev, logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/pic_src_detect.sv
module pic_src_detect
  import pic64_pkg::*;
#(
  parameter bit EDGE_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic [1:0] sense_i,
  input  logic       den_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic s1_q, s2_q;
  logic lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_hit = level_match(s2_q, sense_i[0]);

  generate
    if (EDGE_OK) begin : g_edge
      logic prev_q, latch_q, edge_mode, edge_evt;

      assign edge_mode = sense_i[1];
      assign edge_evt  = den_i & edge_mode & edge_match(s2_q, prev_q, sense_i[0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q  <= 1'b0;
          latch_q <= 1'b0;
        end else begin
          prev_q <= s2_q;
          if (edge_evt)   latch_q <= 1'b1;
          else if (clr_i) latch_q <= 1'b0;
        end
      end

      assign pend_o = den_i & (edge_mode ? latch_q : lvl_hit);

      // R5: a latched edge survives until a clear arrives
      a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i) |=> latch_q);
      // R6: a clear with no new event empties the latch
      a_r6_clear_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_evt) |=> !latch_q);
    end else begin : g_lvl
      logic unused_lvl;
      assign unused_lvl = clr_i ^ sense_i[1];
      assign pend_o     = den_i & lvl_hit;
    end
  endgenerate
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned NSRC   = 64,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        found_o,
  output logic [SRC_W-1:0]            idx_o
);
  logic [PRIO_W-1:0] best;
  logic              unused_top;

  assign unused_top = req_i[NSRC-1];

  // ascending scan with strict compare: lower index keeps a tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < NSRC - 1; i++) begin
      if (req_i[i] && (!found_o || prio_i[i] > best)) begin
        found_o = 1'b1;
        best    = prio_i[i];
        idx_o   = SRC_W'(i);
      end
    end
  end

  // R7: winner is a live request and never the reserved top index
  a_r7_pick_valid: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (req_i[idx_o] && idx_o != SRC_W'(NSRC - 1)));
endmodule

// File: rtl/pic64_ctrl.sv
module pic64_ctrl
  import pic64_pkg::*;
#(
  parameter int unsigned NSRC    = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned EDGE_LO = 47,
  parameter int unsigned EDGE_HI = 50,
  parameter int unsigned CLR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int unsigned SRC_W   = $clog2(NSRC);
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned CFG_END = ADR_CFG_BASE + NSRC * 8;
  localparam logic [STAT_W-1:0] NONE = STAT_W'(NSRC - 1);

  logic                        den_q, oe_q;
  logic [WORD_W-1:0]           mask_q;
  logic [NSRC-1:0][1:0]        en_q, sense_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [STAT_W-1:0]           cur_q;

  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit, cfg_hi;
  logic [SRC_W-1:0]  cfg_idx;
  logic              unused_off;
  logic              clr_hit;
  logic [CLR_W-1:0]  clr_nib;
  logic [NSRC-1:0]   pend, req;
  logic              found;
  logic [SRC_W-1:0]  win_idx;

  // address decode
  assign cfg_off    = reg_addr - ADDR_W'(ADR_CFG_BASE);
  assign cfg_hit    = (int'(reg_addr) >= ADR_CFG_BASE) && (int'(reg_addr) < CFG_END);
  assign cfg_idx    = cfg_off[SRC_W+2:3];
  assign cfg_hi     = cfg_off[2];
  assign unused_off = ^{cfg_off[1:0], cfg_off[ADDR_W-1:SRC_W+3]};

  assign clr_hit = reg_we && (reg_addr == ADDR_W'(ADR_EDGECLR)) && reg_wdata[CLR_ARM];
  assign clr_nib = reg_wdata[CLR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q   <= 1'b0;
      oe_q    <= 1'b0;
      mask_q  <= '0;
      en_q    <= '0;
      sense_q <= '0;
      prio_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(ADR_DETECT))  den_q  <= reg_wdata[0];
      if (reg_addr == ADDR_W'(ADR_OUTEN))   oe_q   <= reg_wdata[0];
      if (reg_addr == ADDR_W'(ADR_MASKLVL)) mask_q <= reg_wdata;
      if (cfg_hit && !cfg_hi) begin
        en_q[cfg_idx]    <= reg_wdata[EN_LSB +: 2];
        sense_q[cfg_idx] <= reg_wdata[SENSE_LSB +: 2];
      end
      if (cfg_hit && cfg_hi) prio_q[cfg_idx] <= reg_wdata[PRIO_W-1:0];
    end
  end

  // per-source detection
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam bit           EDGE_OK = edge_capable(g, EDGE_LO, EDGE_HI);
      localparam logic [CLR_W-1:0] NIB = CLR_W'(g);
      pic_src_detect #(.EDGE_OK(EDGE_OK)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (irq_in[g]),
        .sense_i (sense_q[g]),
        .den_i   (den_q),
        .clr_i   (clr_hit && (clr_nib == NIB)),
        .pend_o  (pend[g])
      );
      assign req[g] = pend[g] & (en_q[g] == 2'b11);
    end
  endgenerate

  pic_prio_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .prio_i  (prio_q),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= NONE;
    else        cur_q <= found ? STAT_W'(win_idx) : NONE;
  end

  assign irq_out = oe_q && (cur_q != NONE);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_DETECT))       reg_rdata[0] = den_q;
    else if (reg_addr == ADDR_W'(ADR_OUTEN))   reg_rdata[0] = oe_q;
    else if (reg_addr == ADDR_W'(ADR_MASKLVL)) reg_rdata = mask_q;
    else if (reg_addr == ADDR_W'(ADR_STATUS))  reg_rdata[STAT_LSB +: STAT_W] = cur_q;
    else if (cfg_hit && !cfg_hi) begin
      reg_rdata[EN_LSB +: 2]    = en_q[cfg_idx];
      reg_rdata[SENSE_LSB +: 2] = sense_q[cfg_idx];
    end else if (cfg_hit) reg_rdata[PRIO_W-1:0] = prio_q[cfg_idx];
  end

  // R9: with detection off, the next status is the idle code
  a_r9_den_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !den_q |=> (cur_q == NONE));
  // R8: status byte never holds a number outside the source range
  a_r8_status_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_q) < NSRC);
endmodule

// File: tb/pic64_ctrl_tb_top.sv
module pic64_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  always #5 clk = ~clk;

  pic64_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench model of programmed state
  logic [1:0]  m_en    [64];
  logic [1:0]  m_sense [64];
  logic [7:0]  m_prio  [64];
  logic        m_latch [64];
  logic        m_den, m_oe;
  logic [63:0] cur_in;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  function automatic bit is_edge_src(int i);
    return i >= 47 && i <= 50;
  endfunction

  function automatic logic m_pending(int i);
    if (is_edge_src(i) && m_sense[i][1]) return m_latch[i];
    return cur_in[i] == m_sense[i][0];
  endfunction

  // descending scan, >= keeps the lowest index on a tie
  function automatic logic [7:0] m_status();
    int win = -1;
    logic [7:0] top = 0;
    for (int i = 62; i >= 0; i--) begin
      if (m_den && m_en[i] == 2'b11 && m_pending(i) && (win < 0 || m_prio[i] >= top)) begin
        win = i; top = m_prio[i];
      end
    end
    return (win < 0) ? 8'd63 : 8'(win);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(input int i, input logic [1:0] en, input logic [1:0] s,
                         input logic [7:0] p, input logic [31:0] junk);
    wr(12'(32'h200 + 8 * i), (junk & 32'hCCFF_FFFF) | {2'b00, en, 2'b00, s, 24'h0});
    wr(12'(32'h204 + 8 * i), (junk & 32'hFFFF_FF00) | {24'h0, p});
    m_en[i] = en; m_sense[i] = s; m_prio[i] = p;
  endtask

  task automatic set_den(input logic v);
    wr(12'h004, {31'h0, v}); m_den = v;
  endtask

  task automatic set_oe(input logic v);
    wr(12'h444, {31'h0, v}); m_oe = v;
  endtask

  task automatic drive(input logic [63:0] nv);
    for (int i = 47; i <= 50; i++) begin
      if (m_den && m_sense[i][1] &&
          (( m_sense[i][0] && !cur_in[i] &&  nv[i]) ||
           (!m_sense[i][0] &&  cur_in[i] && !nv[i])))
        m_latch[i] = 1'b1;
    end
    @(negedge clk); irq_in = nv; cur_in = nv;
    settle();
  endtask

  task automatic edge_clear(input logic [3:0] nib, input logic arm);
    wr(12'h0C0, {23'h0, arm, 4'h0, nib});
    if (arm) for (int i = 47; i <= 50; i++) if (4'(i) == nib) m_latch[i] = 1'b0;
    settle();
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d;
    logic [7:0]  e;
    e = m_status();
    rd(12'h144, d);
    chk(tag, d, {e, 24'h0});
    chk({tag, " irq_out"}, {31'h0, irq_out}, {31'h0, m_oe && e != 8'd63});
  endtask

  task automatic init_cfg();
    for (int i = 0; i < 64; i++) set_cfg(i, 2'b00, 2'b00, 8'h00, 32'h0);
    edge_clear(4'hF, 1'b1); edge_clear(4'h0, 1'b1);
    edge_clear(4'h1, 1'b1); edge_clear(4'h2, 1'b1);
    drive(64'h0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cur_in = '0; m_den = 1'b0; m_oe = 1'b0;
    for (int i = 0; i < 64; i++) begin
      m_en[i] = 0; m_sense[i] = 0; m_prio[i] = 0; m_latch[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h144, d); chk("R1 status after reset", d, 32'h3F00_0000);
    chk("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);
    rd(12'h238, d); chk("R1 config word zero", d, 32'h0);
    rd(12'h004, d); chk("R1 detect enable zero", d, 32'h0);
    rd(12'h444, d); chk("R1 output enable zero", d, 32'h0);

    // R2 readback masks
    wr(12'h250, 32'hFFFF_FFFF); rd(12'h250, d); chk("R2 word A fields", d, 32'h3300_0000);
    wr(12'h254, 32'h00AB_CD12); rd(12'h254, d); chk("R2 word B priority", d, 32'h0000_0012);
    init_cfg();

    // R3 enable pair
    set_den(1'b1); set_oe(1'b1);
    drive(64'h0000_0000_0000_0400);
    set_cfg(10, 2'b01, 2'b01, 8'd5, 32'h0); check_status("R3 enable 01 ignored");
    chk("R3 enable 01 code", {24'h0, m_status()}, 32'd63);
    set_cfg(10, 2'b10, 2'b01, 8'd5, 32'h0); check_status("R3 enable 10 ignored");
    set_cfg(10, 2'b11, 2'b01, 8'd5, 32'h0); check_status("R3 enable 11 reported");
    chk("R3 source 10 code", {24'h0, m_status()}, 32'd10);

    // R11 mask level has no effect
    wr(12'h084, 32'hDEAD_BEEF); rd(12'h084, d); chk("R11 mask readback", d, 32'hDEAD_BEEF);
    check_status("R11 status unchanged by mask");

    // R9 detection enable
    set_den(1'b0); check_status("R9 detect off hides source");
    set_den(1'b1); check_status("R9 detect back on");

    // R10 output enable
    set_oe(1'b0); check_status("R10 output disabled");
    set_oe(1'b1); check_status("R10 output enabled");

    // R7 ties and source 63
    set_cfg(12, 2'b11, 2'b01, 8'd5, 32'h0);
    drive(64'h8000_0000_0000_1400);
    set_cfg(63, 2'b11, 2'b01, 8'd255, 32'h0);
    check_status("R7 tie goes to lower number");
    set_cfg(10, 2'b00, 2'b01, 8'd5, 32'h0);
    check_status("R7 source 63 never reported");
    init_cfg();

    // R4 level polarity and non-edge sources
    set_cfg(20, 2'b11, 2'b00, 8'd3, 32'h0); check_status("R4 active low idle input");
    drive(64'h0000_0000_0010_0000); check_status("R4 active low input high");
    set_cfg(20, 2'b11, 2'b11, 8'd3, 32'h0); check_status("R4 code 3 level high on plain source");
    set_cfg(20, 2'b11, 2'b10, 8'd3, 32'h0); check_status("R4 code 2 level low on plain source");
    init_cfg();

    // R5 / R6 edge latch and clear
    set_cfg(48, 2'b11, 2'b11, 8'd40, 32'h0);
    set_cfg(49, 2'b11, 2'b11, 8'd30, 32'h0);
    set_cfg(47, 2'b11, 2'b10, 8'd20, 32'h0);
    drive(64'h0003_0000_0000_0000); check_status("R5 rising latched 48");
    drive(64'h0000_0000_0000_0000); check_status("R5 latch held after input low");
    chk("R5 source 48 code", {24'h0, m_status()}, 32'd48);
    edge_clear(4'h0, 1'b0); check_status("R6 unarmed clear no effect");
    edge_clear(4'h0, 1'b1); check_status("R6 clear 48 leaves 49");
    chk("R6 source 49 code", {24'h0, m_status()}, 32'd49);
    edge_clear(4'h1, 1'b1);
    drive(64'h0000_8000_0000_0000); check_status("R5 no falling event yet");
    drive(64'h0000_0000_0000_0000); check_status("R5 falling latched 47");
    edge_clear(4'hF, 1'b1); check_status("R6 clear nibble 15 frees 47");
    set_den(1'b0);
    drive(64'h0001_0000_0000_0000); set_den(1'b1); check_status("R9 no edge latched while off");
    drive(64'h0000_0000_0000_0000);
    init_cfg();

    // R12 latency, level then edge
    set_cfg(5, 2'b11, 2'b01, 8'd9, 32'h0);
    @(negedge clk); reg_addr = 12'h144; irq_in[5] = 1'b1; cur_in[5] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R12 level not yet after two edges", reg_rdata, 32'h3F00_0000);
    @(posedge clk); #1;
    chk("R12 level shown after third edge", reg_rdata, 32'h0500_0000);
    set_cfg(5, 2'b00, 2'b01, 8'd9, 32'h0);
    set_cfg(49, 2'b11, 2'b11, 8'd20, 32'h0);
    settle();
    @(negedge clk); reg_addr = 12'h144; irq_in[49] = 1'b1; cur_in[49] = 1'b1; m_latch[49] = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R12 edge not yet after three edges", reg_rdata, 32'h3F00_0000);
    @(posedge clk); #1;
    chk("R12 edge shown after fourth edge", reg_rdata, 32'h3100_0000);
    init_cfg();

    // random phase
    for (int i = 0; i < 64; i++) begin
      logic [1:0] en;
      en = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom);
      set_cfg(i, en, 2'($urandom), 8'($urandom % 8), $urandom);
    end
    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom % 10;
      if (op < 5) begin
        logic [63:0] flip;
        flip = {$urandom, $urandom} & {$urandom, $urandom};
        flip[50:47] = 4'($urandom);
        drive(cur_in ^ flip);
      end else if (op < 7) begin
        set_cfg($urandom % 64, ($urandom % 3 != 0) ? 2'b11 : 2'($urandom),
                2'($urandom), 8'($urandom % 8), $urandom);
        settle();
      end else if (op < 9) begin
        logic [3:0] nibs [5] = '{4'hF, 4'h0, 4'h1, 4'h2, 4'h3};
        edge_clear(nibs[$urandom % 5], 1'($urandom % 4 != 0));
      end else begin
        set_den(1'($urandom % 4 != 0)); set_oe(1'($urandom % 4 != 0));
        settle();
      end
      check_status("R7 random mix");
    end
    finish_run();
  end
endmodule